// File: doc/BRIEF.md
# FIFO Almost-Empty / Almost-Full Threshold Register Bank

This block stores the two threshold values that a deep FIFO's flag comparators use. One value sets how close to empty the almost-empty flag fires, and the other does the same for almost-full. Each threshold is one bit wider than the log2 of the FIFO depth would need, minus one; for a 16,384-word FIFO that is 14 bits. The comparators read both thresholds continuously from two dedicated outputs.

The pair can be written two ways. A slow serial path takes one bit per rising edge of a serial clock while a serial enable is high. The stream carries all of the almost-empty value first, least significant bit first, then all of the almost-full value. A parallel path on the write clock takes a whole threshold from the low bits of the 72-bit data bus whenever a load-select input and the write enable are both high. Successive parallel writes go to almost-empty first and then to almost-full.

A readback path on the read clock returns the thresholds on the 72-bit output bus, almost-empty first, when load-select and the read enable are both high. The read enable must drop for at least one read clock between two readbacks. A request that breaks this rule is dropped and flagged with a one-cycle error pulse. The serial clock, enable and data are oversampled by the write clock through a two-stage synchroniser. Each serial clock phase must therefore last at least three write clock periods.

Top module: `fifo_thresh_regs`

## Requirements
- R1: After reset both thresholds equal 127, the parallel write and readback both start at the almost-empty threshold, the output bus is zero and the error pulse is low.
- R2: Each rising serial clock edge seen while the serial enable is high stores one serial data bit. Stream bit k, for k from 0 to X-1, goes to almost-empty bit k. Stream bit X+k goes to almost-full bit k.
- R3: Rising serial clock edges while the serial enable is low change neither threshold and do not advance the serial bit position.
- R4: After 2X accepted serial bits the position wraps, so the next accepted bit goes to almost-empty bit 0.
- R5: A write clock edge with load-select and the write enable both high stores data-in bits [X-1:0] into one threshold. The targets alternate: the first goes to almost-empty, the next to almost-full, then almost-empty again.
- R6: The write enable with load-select low leaves both thresholds unchanged.
- R7: A write clock edge with load-select low returns the parallel write target to almost-empty. A read clock edge with load-select low returns the readback target to almost-empty.
- R8: An accepted readback, meaning load-select and the read enable are high and the read enable was low on the previous read clock edge, drives the selected threshold on output bits [X-1:0] and zero on all upper bits from that edge on. The selection alternates almost-empty, then almost-full.
- R9: A readback request whose previous read clock edge also saw a request is ignored. The output bus holds, the readback target does not advance, and the error output is high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write clock; also oversamples the serial path |
| rdClk | input | 1 | Read clock for readback |
| rstN | input | 1 | Asynchronous active-low reset |
| loadSel | input | 1 | Marks register access instead of FIFO traffic |
| serClk | input | 1 | Serial load clock |
| serEn | input | 1 | Serial load enable |
| serDin | input | 1 | Serial load data |
| wrEn | input | 1 | Write enable |
| dataIn | input | 72 | Write data bus |
| rdEn | input | 1 | Read enable |
| dataOut | output | 72 | Readback data bus |
| rdErr | output | 1 | One-cycle pulse on a dropped back-to-back readback |
| emptyThr | output | 14 | Almost-empty threshold to the flag logic |
| fullThr | output | 14 | Almost-full threshold to the flag logic |

## Verification
The bench goes after the alternation of targets, a wrap of the serial position, and a return to almost-empty when load-select drops. It also drives a back-to-back readback request. A design that failed to reset the write or readback target would write or read almost-full where almost-empty is expected. One that did not wrap the serial count would lose the bits after the 28th. A design that advanced the readback target on a dropped request would return the wrong threshold on the next legal read, and one that leaked data-in's upper bits would show nonzero high output bits.

// File: rtl/fifo_thresh_pkg.sv
`timescale 1ns/1ps
package fifo_thresh_pkg;
  // Strobes from control to the threshold datapath
  typedef struct packed {
    logic serStb;     // store one serial bit this cycle
    logic serBit;     // the bit value
    logic serToFull;  // bit targets the almost-full threshold
    logic parWrEmpty; // parallel write into almost-empty
    logic parWrFull;  // parallel write into almost-full
  } thrStrobe_t;
endpackage

// File: rtl/fifo_thresh_ctrl.sv
`timescale 1ns/1ps
module fifo_thresh_ctrl
  import fifo_thresh_pkg::*;
#(
  parameter int OFS_W = 14
) (
  input  logic wrClk,
  input  logic rstN,
  input  logic loadSel,
  input  logic serClk,
  input  logic serEn,
  input  logic serDin,
  input  logic wrEn,
  output thrStrobe_t strb,
  output logic [$clog2(OFS_W)-1:0] serIdx
);
  localparam int CNT_W = $clog2(2 * OFS_W);
  localparam int IDX_W = $clog2(OFS_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * OFS_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OFS_W);

  logic [2:0] clkSync;
  logic [1:0] enSync;
  logic [1:0] dinSync;
  logic [CNT_W-1:0] bitCnt;
  logic wrPtr;
  logic serTake;
  logic [CNT_W-1:0] fullPos;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      enSync  <= '0;
      dinSync <= '0;
    end else begin
      clkSync <= {clkSync[1:0], serClk};
      enSync  <= {enSync[0], serEn};
      dinSync <= {dinSync[0], serDin};
    end
  end

  assign serTake = clkSync[1] & ~clkSync[2] & enSync[1];

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (serTake) begin
      bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= 1'b0;
    end else if (!loadSel) begin
      wrPtr <= 1'b0;
    end else if (wrEn) begin
      wrPtr <= ~wrPtr;
    end
  end

  assign fullPos = bitCnt - HALF;

  always_comb begin
    strb.serStb     = serTake;
    strb.serBit     = dinSync[1];
    strb.serToFull  = (bitCnt >= HALF);
    strb.parWrEmpty = loadSel & wrEn & ~wrPtr;
    strb.parWrFull  = loadSel & wrEn & wrPtr;
    serIdx = strb.serToFull ? fullPos[IDX_W-1:0] : bitCnt[IDX_W-1:0];
  end

  AST_WRPTR_HOME: assert property (@(posedge wrClk) disable iff (!rstN)
    !loadSel |=> !strb.parWrFull);  // R7
  AST_SER_CNT_RANGE: assert property (@(posedge wrClk) disable iff (!rstN)
    bitCnt <= LAST);  // R4
  AST_SER_IDLE: assert property (@(posedge wrClk) disable iff (!rstN)
    !serTake |=> $stable(bitCnt));  // R3
  AST_STB_EXCL: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0({strb.parWrEmpty, strb.parWrFull}));  // R5
endmodule

// File: rtl/fifo_thresh_data.sv
`timescale 1ns/1ps
module fifo_thresh_data
  import fifo_thresh_pkg::*;
#(
  parameter int OFS_W = 14,
  parameter int DEF_VAL = 127
) (
  input  logic wrClk,
  input  logic rstN,
  input  thrStrobe_t strb,
  input  logic [$clog2(OFS_W)-1:0] serIdx,
  input  logic [OFS_W-1:0] parVal,
  output logic [OFS_W-1:0] emptyThr,
  output logic [OFS_W-1:0] fullThr
);
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEF_VAL);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      emptyThr <= RST_VAL;
    end else if (strb.parWrEmpty) begin
      emptyThr <= parVal;
    end else if (strb.serStb && !strb.serToFull) begin
      emptyThr[serIdx] <= strb.serBit;
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      fullThr <= RST_VAL;
    end else if (strb.parWrFull) begin
      fullThr <= parVal;
    end else if (strb.serStb && strb.serToFull) begin
      fullThr[serIdx] <= strb.serBit;
    end
  end

  AST_PAR_EMPTY: assert property (@(posedge wrClk) disable iff (!rstN)
    strb.parWrEmpty |=> emptyThr == $past(parVal));  // R5
  AST_PAR_FULL: assert property (@(posedge wrClk) disable iff (!rstN)
    strb.parWrFull |=> fullThr == $past(parVal));  // R5
  AST_QUIET_HOLD: assert property (@(posedge wrClk) disable iff (!rstN)
    !(strb.serStb || strb.parWrEmpty || strb.parWrFull) |=> ($stable(emptyThr) && $stable(fullThr)));  // R6
endmodule

// File: rtl/fifo_thresh_read.sv
`timescale 1ns/1ps
module fifo_thresh_read #(
  parameter int OFS_W = 14,
  parameter int BUS_W = 72
) (
  input  logic rdClk,
  input  logic rstN,
  input  logic loadSel,
  input  logic rdEn,
  input  logic [OFS_W-1:0] emptyThr,
  input  logic [OFS_W-1:0] fullThr,
  output logic [BUS_W-1:0] dataOut,
  output logic rdErr
);
  logic prevReq;
  logic rdPtr;
  logic req;
  logic accept;

  assign req    = loadSel & rdEn;
  assign accept = req & ~prevReq;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      prevReq <= 1'b0;
      rdErr   <= 1'b0;
    end else begin
      prevReq <= req;
      rdErr   <= req & prevReq;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= 1'b0;
    end else if (!loadSel) begin
      rdPtr <= 1'b0;
    end else if (accept) begin
      rdPtr <= ~rdPtr;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (accept) begin
      dataOut <= {{(BUS_W - OFS_W){1'b0}}, (rdPtr ? fullThr : emptyThr)};
    end
  end

  AST_RD_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (req && prevReq) |=> $stable(dataOut));  // R9
  AST_RD_UPPER_ZERO: assert property (@(posedge rdClk) disable iff (!rstN)
    dataOut[BUS_W-1:OFS_W] == '0);  // R8
  AST_RD_FIRST_EMPTY: assert property (@(posedge rdClk) disable iff (!rstN)
    (accept && !rdPtr) |=> dataOut[OFS_W-1:0] == $past(emptyThr));  // R8
  AST_RD_ERR_SINGLE: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdErr && !req) |=> !rdErr);  // R9
endmodule

// File: rtl/fifo_thresh_regs.sv
`timescale 1ns/1ps
module fifo_thresh_regs
  import fifo_thresh_pkg::*;
#(
  parameter int DEPTH = 16384,
  parameter int BUS_W = 72,
  parameter int DEF_VAL = 127,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic wrClk,
  input  logic rdClk,
  input  logic rstN,
  input  logic loadSel,
  input  logic serClk,
  input  logic serEn,
  input  logic serDin,
  input  logic wrEn,
  input  logic [BUS_W-1:0] dataIn,
  input  logic rdEn,
  output logic [BUS_W-1:0] dataOut,
  output logic rdErr,
  output logic [OFS_W-1:0] emptyThr,
  output logic [OFS_W-1:0] fullThr
);
  thrStrobe_t strb;
  logic [$clog2(OFS_W)-1:0] serIdx;
  logic unusedDinHi;

  assign unusedDinHi = ^dataIn[BUS_W-1:OFS_W];

  fifo_thresh_ctrl #(.OFS_W(OFS_W)) ctrl_i (
    .wrClk(wrClk), .rstN(rstN), .loadSel(loadSel), .serClk(serClk),
    .serEn(serEn), .serDin(serDin), .wrEn(wrEn), .strb(strb), .serIdx(serIdx)
  );

  fifo_thresh_data #(.OFS_W(OFS_W), .DEF_VAL(DEF_VAL)) data_i (
    .wrClk(wrClk), .rstN(rstN), .strb(strb), .serIdx(serIdx),
    .parVal(dataIn[OFS_W-1:0]), .emptyThr(emptyThr), .fullThr(fullThr)
  );

  fifo_thresh_read #(.OFS_W(OFS_W), .BUS_W(BUS_W)) read_i (
    .rdClk(rdClk), .rstN(rstN), .loadSel(loadSel), .rdEn(rdEn),
    .emptyThr(emptyThr), .fullThr(fullThr), .dataOut(dataOut), .rdErr(rdErr)
  );
endmodule

// File: tb/fifo_thresh_regs_tb.sv
`timescale 1ns/1ps
module fifo_thresh_regs_tb_top;
  localparam int X = 14;
  localparam int BW = 72;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadSel = 1'b0, serClk = 1'b0, serEn = 1'b0, serDin = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [BW-1:0] dataIn = '0;
  logic [BW-1:0] dataOut;
  logic rdErr;
  logic [X-1:0] emptyThr, fullThr;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_thresh_regs dut_i (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .loadSel(loadSel), .serClk(serClk),
    .serEn(serEn), .serDin(serDin), .wrEn(wrEn), .dataIn(dataIn), .rdEn(rdEn),
    .dataOut(dataOut), .rdErr(rdErr), .emptyThr(emptyThr), .fullThr(fullThr)
  );

  localparam logic [2*X-1:0] VEC [0:3] = '{
    {14'h0001, 14'h3FFF}, {14'h2AAA, 14'h1555},
    {14'h0000, 14'h0080}, {14'h3FFE, 14'h0007}
  };

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic parWr(input logic [X-1:0] v);
    @(negedge clk);
    loadSel = 1'b1; wrEn = 1'b1; dataIn = {{(BW-X){1'b1}}, v};
    @(negedge clk);
    wrEn = 1'b0; dataIn = '0;
  endtask

  task automatic rdOne(output logic [BW-1:0] v);
    @(negedge clk);
    loadSel = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = dataOut;
  endtask

  task automatic serBit(input logic b, input logic en);
    @(negedge clk);
    serEn = en; serDin = b;
    @(negedge clk);
    serClk = 1'b1;
    repeat (4) @(negedge clk);
    serClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic serWord(input logic [X-1:0] e, input logic [X-1:0] f);
    for (int i = 0; i < X; i++) serBit(e[i], 1'b1);
    for (int i = 0; i < X; i++) serBit(f[i], 1'b1);
  endtask

  task automatic dropLd();
    @(negedge clk);
    loadSel = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 emptyThr", BW'(emptyThr), BW'(127));
    chk("R1 fullThr", BW'(fullThr), BW'(127));
    chk("R1 dataOut", dataOut, '0);
    chk("R1 rdErr", BW'(rdErr), '0);
    rdOne(r); chk("R1 first read is empty", r, BW'(127));
    dropLd();

    // R5 R8 vector table
    foreach (VEC[k]) begin
      parWr(VEC[k][2*X-1:X]);
      parWr(VEC[k][X-1:0]);
      chk("R5 empty write", BW'(emptyThr), BW'(VEC[k][2*X-1:X]));
      chk("R5 full write", BW'(fullThr), BW'(VEC[k][X-1:0]));
      rdOne(r); chk("R8 read empty, upper zero", r, BW'(VEC[k][2*X-1:X]));
      rdOne(r); chk("R8 read full, upper zero", r, BW'(VEC[k][X-1:0]));
      dropLd();
    end

    // R5 third write wraps back to empty
    parWr(14'h0100); parWr(14'h0200); parWr(14'h0300);
    chk("R5 third write to empty", BW'(emptyThr), BW'(14'h0300));
    chk("R5 full kept", BW'(fullThr), BW'(14'h0200));
    dropLd();

    // R6 write enable without load-select
    @(negedge clk);
    loadSel = 1'b0; wrEn = 1'b1; dataIn = BW'(14'h0005);
    repeat (3) @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
    chk("R6 empty unchanged", BW'(emptyThr), BW'(14'h0300));
    chk("R6 full unchanged", BW'(fullThr), BW'(14'h0200));

    // R7 pointers return home on load-select low
    parWr(14'h0011);
    dropLd();
    parWr(14'h0022);
    chk("R7 write pointer home", BW'(emptyThr), BW'(14'h0022));
    chk("R7 full untouched", BW'(fullThr), BW'(14'h0200));
    rdOne(r);
    dropLd();
    rdOne(r); chk("R7 read pointer home", r, BW'(14'h0022));
    dropLd();

    // R9 back-to-back readback
    @(negedge clk);
    loadSel = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    chk("R9 first read ok", dataOut, BW'(14'h0022));
    chk("R9 no error on legal read", BW'(rdErr), '0);
    @(negedge clk);
    rdEn = 1'b0;
    chk("R9 output held", dataOut, BW'(14'h0022));
    chk("R9 error pulse", BW'(rdErr), BW'(1));
    @(negedge clk);
    chk("R9 error one cycle", BW'(rdErr), '0);
    rdOne(r); chk("R9 pointer not advanced", r, BW'(14'h0200));
    dropLd();

    // R2 serial word
    serWord(14'h1234, 14'h2ABC);
    chk("R2 serial empty", BW'(emptyThr), BW'(14'h1234));
    chk("R2 serial full", BW'(fullThr), BW'(14'h2ABC));

    // R3 disabled edges ignored
    for (int i = 0; i < 3; i++) serBit(1'b1, 1'b0);
    chk("R3 empty unchanged", BW'(emptyThr), BW'(14'h1234));
    chk("R3 full unchanged", BW'(fullThr), BW'(14'h2ABC));
    serWord(14'h0F0F, 14'h30C3);
    chk("R3 count not advanced empty", BW'(emptyThr), BW'(14'h0F0F));
    chk("R3 count not advanced full", BW'(fullThr), BW'(14'h30C3));

    // R4 wrap to empty bit 0
    for (int i = 0; i < X; i++) serBit(i[0], 1'b1);
    chk("R4 wrap into empty", BW'(emptyThr), BW'(14'h2AAA));
    chk("R4 full kept", BW'(fullThr), BW'(14'h30C3));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule